// File: doc/BRIEF.md
# Endpoint-Zero Control Transfer Sequencer

This block steers control transfers on endpoint zero of a USB device controller. It takes in the eight bytes of a setup packet one byte at a time and decodes the direction bit, the request code, the low byte of the value field and the requested length. It then runs one of three paths. A device-to-host request gets a data stage cut into packets. A host-to-device request with no data goes straight to a zero-byte IN status packet. A host-to-device request that carries data is refused with a stall.

During a control read the block keeps a running count of the bytes the host has acknowledged. Each packet it asks for holds the maximum packet size or the remaining bytes, whichever is smaller. When the last packet is acknowledged, the block decides between a zero-length terminating packet and the end of the stage. At the end of the stage it clears and arms the receive FIFO so the host's OUT status packet can be taken. A standard set-configuration request with no data moves a configured flag up or down, but only from the right device state.

The FIFO side sees single-cycle strobes: transmit enable with a packet length, transmit clear, receive enable and receive clear. It also sees a level stall flag for endpoint zero. Handshake results come back as ACK and STALL pulses, one pair for each direction.

Top module: `ep0_ctrl_seq`

## Requirements
- R1: After reset every FIFO strobe is low, `tx_len` is 0, `ep0_stall` is low and `configured` is low.
- R2: A `setup_start` pulse begins capture of a setup packet, and the next eight `setup_vld` bytes fill it. The packet is decoded on the clock after the eighth byte and the outputs react on the clock after that. A new `setup_start` at any time aborts the transfer in progress. The old transfer's handshakes then have no effect, and the latest packet is the one that gets decoded. Field positions: byte 0 bit 7 is the direction (1 = device to host), byte 1 is the request code, byte 2 is the value low byte, and bytes 6 (low) and 7 (high) are the requested length.
- R3: A host-to-device request with a nonzero length sets `ep0_stall` and issues no transmit strobe.
- R4: A host-to-device request with length 0 pulses `tx_fifo_clr` and `tx_fifo_en` together, with `tx_len` = 0.
- R5: For a device-to-host request, the response length is min(`resp_len`, requested length). Every packet strobed on `tx_fifo_en` carries min(MAX_PKT, bytes not yet acknowledged). The first packet goes out on decode and each later packet goes out one clock after a `tx_ack`.
- R6: Request code 9 (set configuration) with length 0 sets `configured` when the value byte is nonzero, `dev_addressed` is high and the device is not configured. It clears `configured` when the value byte is 0 and the device is configured. In every other case the flag is left unchanged.
- R7: On a data-stage `tx_ack`, the sent count grows by the last packet's length. The stage ends when the sent count equals the response length and either the response length equals the requested length or the last packet was shorter than MAX_PKT. Otherwise another packet follows, and that packet may have zero length.
- R8: At the end of the data stage, `rx_fifo_clr` and `rx_fifo_en` pulse together for one cycle.
- R9: While the last decoded request is host-to-device, an `rx_ack` pulses `rx_fifo_clr` (without `rx_fifo_en`) and sets `ep0_stall`.
- R10: A `tx_stall` or `rx_stall` in the direction being waited on returns the block to idle. A later `tx_ack` for that transfer then produces no strobe.
- R11: `ep0_stall` stays set until the next setup packet is decoded, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| setup_start | input | 1 | Marks the start of a new setup packet |
| setup_vld | input | 1 | A setup byte is present on `setup_byte` |
| setup_byte | input | 8 | Setup packet byte |
| resp_len | input | LEN_W | Byte count of the device's reply, sampled on decode |
| dev_addressed | input | 1 | Device holds an assigned address |
| tx_ack | input | 1 | Host acknowledged the IN packet |
| tx_stall | input | 1 | IN transaction ended in STALL |
| rx_ack | input | 1 | OUT packet acknowledged on endpoint zero |
| rx_stall | input | 1 | OUT transaction ended in STALL |
| tx_fifo_en | output | 1 | Arm the transmit FIFO with `tx_len` bytes |
| tx_fifo_clr | output | 1 | Clear the transmit FIFO |
| tx_len | output | LEN_W | Length of the packet being armed |
| rx_fifo_en | output | 1 | Arm the receive FIFO |
| rx_fifo_clr | output | 1 | Clear the receive FIFO |
| ep0_stall | output | 1 | Endpoint zero answers with STALL |
| configured | output | 1 | Device is in the configured state |

## Verification
The bench aims at the ends of the length rule. These cases are a reply that is an exact multiple of the packet size and shorter than requested (a design that skips the zero-length packet leaves the host waiting), the same reply at exactly the requested length (a design that adds a zero-length packet sends one too many), a zero-byte reply, and a reply clipped by a small requested length. It restarts a setup in the middle of a data stage and then acknowledges as if the old transfer were still running. A design that fails to abort would send stale packets. It also sends set-configuration with a zero value, with a nonzero value and with the device unaddressed, to catch a flag that moves from the wrong state, and it drives an OUT acknowledge during a no-data request, which must end in a stall.

// File: rtl/ep0_seq_pkg.sv
package ep0_seq_pkg;
  typedef enum logic [2:0] {
    S_IDLE     = 3'd0,
    S_DATA     = 3'd1,
    S_STAT_OUT = 3'd2,
    S_STAT_IN  = 3'd3,
    S_HALT     = 3'd4
  } ep0_state_e;

  localparam logic [7:0] REQ_SET_CONFIG = 8'd9;
  localparam int unsigned SETUP_BYTES   = 8;
endpackage

// File: rtl/ep0_setup_cap.sv
module ep0_setup_cap
  import ep0_seq_pkg::*;
#(
  parameter int unsigned LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             vld,
  input  logic [7:0]       data,
  output logic             done,
  output logic             dir_in,
  output logic [7:0]       req_code,
  output logic [7:0]       val_lo,
  output logic [LEN_W-1:0] wlen
);
  localparam int unsigned CNT_W = $clog2(SETUP_BYTES);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_q, done_d;
  logic             dir_q;
  logic [7:0]       req_q, val_q, wl_lo_q, wl_hi_q;
  logic             cap_en;

  assign cap_en = vld && !start;

  always_comb begin
    cnt_d  = cnt_q;
    done_d = 1'b0;
    if (start) begin
      cnt_d = '0;
    end else if (vld) begin
      cnt_d  = cnt_q + 1'b1;
      done_d = (cnt_q == CNT_W'(SETUP_BYTES - 1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= 1'b0;
      req_q   <= '0;
      val_q   <= '0;
      wl_lo_q <= '0;
      wl_hi_q <= '0;
    end else if (cap_en) begin
      case (cnt_q)
        CNT_W'(0): dir_q   <= data[7];
        CNT_W'(1): req_q   <= data;
        CNT_W'(2): val_q   <= data;
        CNT_W'(6): wl_lo_q <= data;
        CNT_W'(7): wl_hi_q <= data;
        default: ;
      endcase
    end
  end

  assign done     = done_q;
  assign dir_in   = dir_q;
  assign req_code = req_q;
  assign val_lo   = val_q;
  assign wlen     = LEN_W'({wl_hi_q, wl_lo_q});

  // R2: a decode strobe only follows an accepted byte
  p_done_after_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> $past(vld) && !$past(start));
endmodule

// File: rtl/ep0_rd_track.sv
module ep0_rd_track #(
  parameter int unsigned LEN_W   = 16,
  parameter int unsigned MAX_PKT = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             load,
  input  logic             step,
  input  logic [LEN_W-1:0] resp_len,
  input  logic [LEN_W-1:0] req_len,
  output logic [LEN_W-1:0] first_len,
  output logic [LEN_W-1:0] next_len,
  output logic             fin
);
  localparam logic [LEN_W-1:0] MPS = LEN_W'(MAX_PKT);

  logic [LEN_W-1:0] total_q, wl_q, sent_q, last_q;
  logic [LEN_W-1:0] total_in, sum, remain;

  assign total_in  = (resp_len < req_len) ? resp_len : req_len;
  assign first_len = (total_in > MPS) ? MPS : total_in;
  assign sum       = sent_q + last_q;
  assign remain    = total_q - sum;
  assign next_len  = (remain > MPS) ? MPS : remain;
  assign fin       = (sum == total_q) && ((total_q == wl_q) || (last_q != MPS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      total_q <= '0;
      wl_q    <= '0;
      sent_q  <= '0;
      last_q  <= '0;
    end else if (clr) begin
      total_q <= '0;
      wl_q    <= '0;
      sent_q  <= '0;
      last_q  <= '0;
    end else if (load) begin
      total_q <= total_in;
      wl_q    <= req_len;
      sent_q  <= '0;
      last_q  <= first_len;
    end else if (step) begin
      sent_q  <= sum;
      last_q  <= next_len;
    end
  end

  // R7: acknowledged bytes never pass the response length
  p_sent_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sent_q <= total_q) && (last_q <= MPS));
endmodule

// File: rtl/ep0_cfg_flag.sv
module ep0_cfg_flag (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       apply,
  input  logic [7:0] val_lo,
  input  logic       addressed,
  output logic       configured
);
  logic cfg_q, cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (apply) begin
      if ((val_lo != 8'd0) && addressed && !cfg_q) cfg_d = 1'b1;
      else if ((val_lo == 8'd0) && cfg_q)           cfg_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= 1'b0;
    else        cfg_q <= cfg_d;
  end

  assign configured = cfg_q;

  // R6: the flag only moves on a set-configuration request
  p_cfg_moves_on_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_q) |-> $past(apply));
endmodule

// File: rtl/ep0_ctrl_seq.sv
module ep0_ctrl_seq
  import ep0_seq_pkg::*;
#(
  parameter int unsigned LEN_W   = 16,
  parameter int unsigned MAX_PKT = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             setup_start,
  input  logic             setup_vld,
  input  logic [7:0]       setup_byte,
  input  logic [LEN_W-1:0] resp_len,
  input  logic             dev_addressed,
  input  logic             tx_ack,
  input  logic             tx_stall,
  input  logic             rx_ack,
  input  logic             rx_stall,
  output logic             tx_fifo_en,
  output logic             tx_fifo_clr,
  output logic [LEN_W-1:0] tx_len,
  output logic             rx_fifo_en,
  output logic             rx_fifo_clr,
  output logic             ep0_stall,
  output logic             configured
);
  localparam logic [LEN_W-1:0] MPS = LEN_W'(MAX_PKT);

  logic             dec, dir_in;
  logic [7:0]       req_code, val_lo;
  logic [LEN_W-1:0] wlen, first_len, next_len;
  logic             fin, rd_load, rd_step, cfg_apply;

  ep0_state_e       st_q, st_d;
  logic             dvalid_q, dvalid_d, dir_q, dir_d;
  logic             stall_q, stall_d;
  logic             txen_d, txclr_d, rxen_d, rxclr_d;
  logic             txen_q, txclr_q, rxen_q, rxclr_q;
  logic [LEN_W-1:0] txlen_q, txlen_d;

  ep0_setup_cap #(.LEN_W(LEN_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .start(setup_start), .vld(setup_vld),
    .data(setup_byte), .done(dec), .dir_in(dir_in), .req_code(req_code),
    .val_lo(val_lo), .wlen(wlen)
  );

  ep0_rd_track #(.LEN_W(LEN_W), .MAX_PKT(MAX_PKT)) u_trk (
    .clk(clk), .rst_n(rst_n), .clr(setup_start), .load(rd_load),
    .step(rd_step), .resp_len(resp_len), .req_len(wlen),
    .first_len(first_len), .next_len(next_len), .fin(fin)
  );

  assign cfg_apply = dec && !setup_start && !dir_in && (wlen == '0) &&
                     (req_code == REQ_SET_CONFIG);

  ep0_cfg_flag u_cfg (
    .clk(clk), .rst_n(rst_n), .apply(cfg_apply), .val_lo(val_lo),
    .addressed(dev_addressed), .configured(configured)
  );

  assign rd_load = dec && !setup_start && dir_in;
  assign rd_step = !setup_start && !dec && (st_q == S_DATA) && !tx_stall &&
                   tx_ack && !(rx_ack && dvalid_q && !dir_q);

  always_comb begin
    st_d     = st_q;
    dvalid_d = dvalid_q;
    dir_d    = dir_q;
    stall_d  = stall_q;
    txlen_d  = txlen_q;
    txen_d   = 1'b0;
    txclr_d  = 1'b0;
    rxen_d   = 1'b0;
    rxclr_d  = 1'b0;
    if (setup_start) begin
      st_d     = S_IDLE;
      dvalid_d = 1'b0;
    end else if (dec) begin
      dvalid_d = 1'b1;
      dir_d    = dir_in;
      stall_d  = 1'b0;
      if (dir_in) begin
        st_d    = S_DATA;
        txen_d  = 1'b1;
        txlen_d = first_len;
      end else if (wlen != '0) begin
        st_d    = S_HALT;
        stall_d = 1'b1;
      end else begin
        st_d    = S_STAT_IN;
        txen_d  = 1'b1;
        txclr_d = 1'b1;
        txlen_d = '0;
      end
    end else if (rx_ack && dvalid_q && !dir_q) begin
      st_d    = S_HALT;
      rxclr_d = 1'b1;
      stall_d = 1'b1;
    end else begin
      case (st_q)
        S_DATA: begin
          if (tx_stall) begin
            st_d = S_IDLE;
          end else if (tx_ack) begin
            if (fin) begin
              st_d    = S_STAT_OUT;
              rxen_d  = 1'b1;
              rxclr_d = 1'b1;
            end else begin
              txen_d  = 1'b1;
              txlen_d = next_len;
            end
          end
        end
        S_STAT_OUT: if (rx_ack || rx_stall) st_d = S_IDLE;
        S_STAT_IN:  if (tx_ack || tx_stall) st_d = S_IDLE;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= S_IDLE;
      dvalid_q <= 1'b0;
      dir_q    <= 1'b0;
      stall_q  <= 1'b0;
      txlen_q  <= '0;
      txen_q   <= 1'b0;
      txclr_q  <= 1'b0;
      rxen_q   <= 1'b0;
      rxclr_q  <= 1'b0;
    end else begin
      st_q     <= st_d;
      dvalid_q <= dvalid_d;
      dir_q    <= dir_d;
      stall_q  <= stall_d;
      txlen_q  <= txlen_d;
      txen_q   <= txen_d;
      txclr_q  <= txclr_d;
      rxen_q   <= rxen_d;
      rxclr_q  <= rxclr_d;
    end
  end

  assign tx_fifo_en  = txen_q;
  assign tx_fifo_clr = txclr_q;
  assign tx_len      = txlen_q;
  assign rx_fifo_en  = rxen_q;
  assign rx_fifo_clr = rxclr_q;
  assign ep0_stall   = stall_q;

  // R3: a stalled endpoint arms no transmit packet
  p_stall_no_tx_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ep0_stall |-> !tx_fifo_en);
  // R4: a transmit clear only comes with a zero-length arm
  p_status_zlp_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_fifo_clr |-> tx_fifo_en && (tx_len == '0));
  // R5: packets never exceed the maximum size
  p_len_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_fifo_en |-> (tx_len <= MPS));
  // R8: arming the receive side always clears it first
  p_rx_arm_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_fifo_en |-> rx_fifo_clr && !tx_fifo_en);
  // R10: a STALL in the data stage is followed by no strobe
  p_stall_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_DATA && tx_stall && !setup_start && !dec && !rx_ack) |=>
      !tx_fifo_en && !rx_fifo_en);
endmodule

// File: tb/sim_ep0_ctrl_seq.sv
module sim_ep0_ctrl_seq;
  localparam int LEN_W = 16;
  localparam int MPS   = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic setup_start = 0, setup_vld = 0;
  logic [7:0] setup_byte = '0;
  logic [LEN_W-1:0] resp_len = '0;
  logic dev_addressed = 0, tx_ack = 0, tx_stall = 0, rx_ack = 0, rx_stall = 0;
  logic tx_fifo_en, tx_fifo_clr, rx_fifo_en, rx_fifo_clr, ep0_stall, configured;
  logic [LEN_W-1:0] tx_len;

  always #2.5 clk = ~clk;

  ep0_ctrl_seq #(.LEN_W(LEN_W), .MAX_PKT(MPS)) u0 (
    .clk(clk), .rst_n(rst_n), .setup_start(setup_start), .setup_vld(setup_vld),
    .setup_byte(setup_byte), .resp_len(resp_len), .dev_addressed(dev_addressed),
    .tx_ack(tx_ack), .tx_stall(tx_stall), .rx_ack(rx_ack), .rx_stall(rx_stall),
    .tx_fifo_en(tx_fifo_en), .tx_fifo_clr(tx_fifo_clr), .tx_len(tx_len),
    .rx_fifo_en(rx_fifo_en), .rx_fifo_clr(rx_fifo_clr), .ep0_stall(ep0_stall),
    .configured(configured)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: 0 idle, 1 data, 2 status out, 3 status in, 4 halted
  int m_st, m_cnt, m_tot, m_wl, m_sent, m_last, m_len;
  bit m_done, m_dv, m_dir, m_stall, m_cfg;
  bit e_txen, e_txclr, e_rxen, e_rxclr;
  int e_txlen;
  int b [8];

  function automatic int imin(input int a, input int c);
    return (a < c) ? a : c;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_tot = 0; m_wl = 0; m_sent = 0; m_last = 0;
      m_done = 0; m_dv = 0; m_dir = 0; m_stall = 0; m_cfg = 0;
      e_txen = 0; e_txclr = 0; e_rxen = 0; e_rxclr = 0; e_txlen = 0;
      foreach (b[i]) b[i] = 0;
    end else begin
      e_txen = 0; e_txclr = 0; e_rxen = 0; e_rxclr = 0;
      if (setup_start) begin
        m_cnt = 0; m_st = 0; m_dv = 0; m_done = 0; m_sent = 0; m_last = 0;
      end else begin
        if (m_done) begin
          m_dir = b[0][7]; m_wl = b[6] + 256 * b[7]; m_dv = 1; m_stall = 0;
          if (m_dir) begin
            m_tot = imin(resp_len, m_wl); m_len = imin(MPS, m_tot);
            m_sent = 0; m_last = m_len; e_txen = 1; e_txlen = m_len; m_st = 1;
          end else if (m_wl != 0) begin
            m_stall = 1; m_st = 4;
          end else begin
            e_txen = 1; e_txclr = 1; e_txlen = 0; m_st = 3;
            if (b[1] == 9) begin
              if (b[2] != 0 && dev_addressed && !m_cfg) m_cfg = 1;
              else if (b[2] == 0 && m_cfg) m_cfg = 0;
            end
          end
        end else if (rx_ack && m_dv && !m_dir) begin
          e_rxclr = 1; m_stall = 1; m_st = 4;
        end else if (m_st == 1) begin
          if (tx_stall) m_st = 0;
          else if (tx_ack) begin
            m_sent += m_last;
            if (m_sent == m_tot && (m_tot == m_wl || m_last != MPS)) begin
              e_rxclr = 1; e_rxen = 1; m_st = 2;
            end else begin
              m_len = imin(MPS, m_tot - m_sent); m_last = m_len;
              e_txen = 1; e_txlen = m_len;
            end
          end
        end else if (m_st == 2) begin
          if (rx_ack || rx_stall) m_st = 0;
        end else if (m_st == 3) begin
          if (tx_ack || tx_stall) m_st = 0;
        end
        m_done = 0;
        if (setup_vld) begin
          b[m_cnt] = setup_byte;
          if (m_cnt == 7) begin m_done = 1; m_cnt = 0; end
          else m_cnt++;
        end
      end
    end
  end

  int pkts = 0, zlps = 0, rxarms = 0;
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(tx_fifo_en == e_txen, "R5 tx_fifo_en", tx_fifo_en, e_txen);
      chk(tx_fifo_clr == e_txclr, "R4 tx_fifo_clr", tx_fifo_clr, e_txclr);
      if (e_txen) chk(tx_len == e_txlen, "R5 tx_len", tx_len, e_txlen);
      chk(rx_fifo_en == e_rxen, "R8 rx_fifo_en", rx_fifo_en, e_rxen);
      chk(rx_fifo_clr == e_rxclr, "R9 rx_fifo_clr", rx_fifo_clr, e_rxclr);
      chk(ep0_stall == m_stall, "R3 ep0_stall", ep0_stall, m_stall);
      chk(configured == m_cfg, "R6 configured", configured, m_cfg);
      if (tx_fifo_en) pkts++;
      if (tx_fifo_en && tx_len == 0) zlps++;
      if (rx_fifo_en) rxarms++;
    end
  end

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic setup(input bit dir, input int req, input int val, input int wl);
    setup_start = 1; step(); setup_start = 0;
    for (int i = 0; i < 8; i++) begin
      setup_vld = 1;
      case (i)
        0: setup_byte = {dir, 7'd0};
        1: setup_byte = 8'(req);
        2: setup_byte = 8'(val);
        6: setup_byte = 8'(wl);
        7: setup_byte = 8'(wl >> 8);
        default: setup_byte = 8'h5a;
      endcase
      step();
    end
    setup_vld = 0; step(3);
  endtask

  task automatic pulse_tx_ack();  tx_ack = 1;   step(); tx_ack = 0;   step(2); endtask
  task automatic pulse_rx_ack();  rx_ack = 1;   step(); rx_ack = 0;   step(2); endtask
  task automatic pulse_tx_stall(); tx_stall = 1; step(); tx_stall = 0; step(2); endtask
  task automatic clear_counts(); pkts = 0; zlps = 0; rxarms = 0; endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1; errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    step(3); rst_n = 1; step(1);
    // R1 reset state
    chk(!tx_fifo_en && !rx_fifo_en && !tx_fifo_clr && !rx_fifo_clr, "R1 strobes", 0, 0);
    chk(!ep0_stall && !configured && tx_len == 0, "R1 flags", ep0_stall, 0);

    // R6 unaddressed set-configuration leaves flag low
    dev_addressed = 0; setup(0, 9, 1, 0); pulse_tx_ack();
    chk(configured == 0, "R6 unaddressed", configured, 0);
    dev_addressed = 1; clear_counts(); setup(0, 9, 2, 0);
    chk(zlps == 1, "R4 status zlp", zlps, 1);
    pulse_tx_ack();
    chk(configured == 1, "R6 configure", configured, 1);
    setup(0, 9, 0, 0); pulse_tx_ack();
    chk(configured == 0, "R6 deconfigure", configured, 0);

    // R3 OUT with data stalls; R9 OUT ack stalls; R11 cleared by next setup
    clear_counts(); setup(0, 7, 0, 4);
    chk(ep0_stall == 1 && pkts == 0, "R3 stall", ep0_stall, 1);
    pulse_rx_ack();
    setup(0, 5, 3, 0); pulse_rx_ack();
    chk(ep0_stall == 1, "R9 unexpected rx ack", ep0_stall, 1);
    setup(1, 6, 0, 4);
    chk(ep0_stall == 0, "R11 stall cleared", ep0_stall, 0);
    pulse_tx_ack(); pulse_rx_ack();

    // R5 R7: 18 of 64 -> 8,8,2
    resp_len = 18; clear_counts(); setup(1, 6, 0, 64);
    repeat (3) pulse_tx_ack();
    chk(pkts == 3 && zlps == 0, "R5 short tail", pkts, 3);
    chk(rxarms == 1, "R8 rx armed", rxarms, 1);
    pulse_rx_ack();
    // R7 exact multiple, short of request -> zero-length packet
    resp_len = 16; clear_counts(); setup(1, 6, 0, 64);
    repeat (3) pulse_tx_ack();
    chk(pkts == 3 && zlps == 1, "R7 zlp needed", zlps, 1);
    pulse_rx_ack();
    // R7 exact request length -> no zero-length packet
    clear_counts(); setup(1, 6, 0, 16);
    repeat (2) pulse_tx_ack();
    chk(pkts == 2 && zlps == 0 && rxarms == 1, "R7 no zlp", pkts, 2);
    pulse_rx_ack();
    // R5 clipped by request length
    resp_len = 18; clear_counts(); setup(1, 6, 0, 4);
    pulse_tx_ack();
    chk(pkts == 1 && rxarms == 1, "R5 clipped", pkts, 1);
    // R7 zero-byte reply
    resp_len = 0; clear_counts(); setup(1, 6, 0, 8);
    pulse_tx_ack();
    chk(pkts == 1 && zlps == 1 && rxarms == 1, "R7 empty reply", pkts, 1);

    // R2 abort mid data stage, new setup wins
    resp_len = 40; clear_counts(); setup(1, 6, 0, 64);
    pulse_tx_ack();
    setup(0, 5, 1, 0);
    chk(zlps == 1, "R2 new setup wins", zlps, 1);
    clear_counts(); pulse_tx_ack(); pulse_tx_ack();
    chk(pkts == 0, "R2 stale acks ignored", pkts, 0);

    // R10 stall during data stage
    resp_len = 30; clear_counts(); setup(1, 6, 0, 64);
    pulse_tx_stall(); pulse_tx_ack();
    chk(pkts == 1 && rxarms == 0, "R10 stall ends transfer", pkts, 1);

    step(4);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule